// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent page-to-frame mappings for one process and turns a logical address, given as a page number and an in-page offset, into a physical address in the same cycle. Every stored page number is compared with the incoming one at once. On a match the stored frame number is placed above the unchanged offset. Each entry also carries a present bit and read, write and execute permission bits, and the access type is checked against them.

When no entry matches, the block raises a miss request that carries the page number. An outside page-table walker later answers through the fill port with the page, the frame and its permission bits, and the block installs that mapping. A flush strobe, used on a context switch, empties the whole array on the next clock edge. The choice of slot on a fill goes in this order: the slot that already holds the same page, then the lowest-numbered empty slot, then the slot named by a rotating pointer.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: On a hit, physAddr carries the stored frame in its upper FRAME_W bits and lookupOffset unchanged in its lower OFFSET_W bits, in the same cycle as the lookup.
- R3: When lookupValid is high and no valid entry holds lookupPage, missReq is 1, missPage equals lookupPage, and hit, fault and physAddr are 0. missPage is 0 whenever missReq is 0.
- R4: A fill accepted at a clock edge makes later lookups of that page hit with the supplied frame.
- R5: A flush clears every entry at the next clock edge, so all later lookups miss until new fills arrive.
- R6: accessKind encodes 2'b00 read, 2'b01 write, 2'b10 execute and 2'b11 no access. A matching, present entry whose permission bit for the requested kind is clear, or any match with kind 2'b11, gives fault=1 with hit, missReq and physAddr at 0.
- R7: A matching entry whose present bit is clear gives fault=1 for every access kind, whatever its permission bits.
- R8: A fill for a page not held goes into the lowest-numbered empty slot when one exists, without regard to the rotating pointer.
- R9: When all slots are full, a fill for a new page replaces the slot named by a rotating pointer. The pointer is 0 after reset, is left alone by flush, and steps by one, wrapping at ENTRIES, after every accepted fill of any kind.
- R10: A fill for a page that is already held overwrites that slot, so no page is ever held twice.
- R11: When flush and fillValid are high in the same cycle, the flush happens and the fill is dropped without moving the pointer.
- R12: When lookupValid is low, hit, missReq, fault, missPage and physAddr are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | A translation is requested this cycle |
| lookupPage | input | PAGE_W | Page number of the logical address |
| lookupOffset | input | OFFSET_W | Offset within the page |
| accessKind | input | 2 | 00 read, 01 write, 10 execute, 11 no access |
| fillValid | input | 1 | Install a mapping at the next edge |
| fillPage | input | PAGE_W | Page number to install |
| fillFrame | input | FRAME_W | Frame number to install |
| fillPresent | input | 1 | Page-table present bit for the mapping |
| fillRead | input | 1 | Read permitted |
| fillWrite | input | 1 | Write permitted |
| fillExec | input | 1 | Execute permitted |
| flush | input | 1 | Empty every entry at the next edge |
| physAddr | output | FRAME_W+OFFSET_W | Physical address, valid with hit |
| hit | output | 1 | Lookup translated with permission |
| missReq | output | 1 | No entry holds lookupPage |
| missPage | output | PAGE_W | Page number to be walked |
| fault | output | 1 | Match found but access not allowed |

## Verification
The bench builds the block with four entries, an 8-bit page, a 6-bit frame and a 4-bit offset. Four slots let a short directed sequence fill the array, wrap the rotating pointer more than once and tell the empty-slot-first rule apart from pure rotation after a flush. The narrow fields keep every expected physical address easy to state as a concatenation.

// File: rtl/xc_pkg.sv
package xc_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_NONE  = 2'b11
  } accKind_e;

  typedef struct packed {
    logic present;
    logic canRead;
    logic canWrite;
    logic canExec;
  } perm_t;

  typedef struct packed {
    logic clearAll;
    logic writeEn;
  } strobe_t;

endpackage

// File: rtl/xc_array.sv
module xc_array
  import xc_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int PAGE_W   = 20,
  parameter int FRAME_W  = 17,
  parameter int OFFSET_W = 12,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W    = FRAME_W + OFFSET_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [IDX_W-1:0]    writeIdx,
  input  logic [PAGE_W-1:0]   fillPage,
  input  logic [FRAME_W-1:0]  fillFrame,
  input  perm_t               fillPerm,
  input  logic                lookupValid,
  input  logic [PAGE_W-1:0]   lookupPage,
  input  logic [OFFSET_W-1:0] lookupOffset,
  input  logic [1:0]          accessKind,
  output logic [ENTRIES-1:0]  validVec,
  output logic [ENTRIES-1:0]  fillMatch,
  output logic [PA_W-1:0]     physAddr,
  output logic                hit,
  output logic                missReq,
  output logic [PAGE_W-1:0]   missPage,
  output logic                fault
);

  logic [PAGE_W-1:0]  keyMem   [ENTRIES];
  logic [FRAME_W-1:0] frameMem [ENTRIES];
  perm_t              permMem  [ENTRIES];
  logic [ENTRIES-1:0] lookMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strb.clearAll) begin
      validVec <= '0;
    end else if (strb.writeEn) begin
      validVec[writeIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.writeEn) begin
      keyMem[writeIdx]   <= fillPage;
      frameMem[writeIdx] <= fillFrame;
      permMem[writeIdx]  <= fillPerm;
    end
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lookMatch[e] = validVec[e] && (keyMem[e] == lookupPage);
    assign fillMatch[e] = validVec[e] && (keyMem[e] == fillPage);
  end

  logic [IDX_W-1:0] selIdx;
  logic             anyMatch;

  always_comb begin
    selIdx   = '0;
    anyMatch = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (lookMatch[e]) begin
        selIdx   = IDX_W'(e);
        anyMatch = 1'b1;
      end
    end
  end

  perm_t selPerm;
  logic  allowed;

  always_comb begin
    selPerm = permMem[selIdx];
    unique case (accessKind)
      2'b00:   allowed = selPerm.canRead;
      2'b01:   allowed = selPerm.canWrite;
      2'b10:   allowed = selPerm.canExec;
      default: allowed = 1'b0;
    endcase
    allowed = allowed && selPerm.present;
  end

  always_comb begin
    hit      = lookupValid && anyMatch && allowed;
    fault    = lookupValid && anyMatch && !allowed;
    missReq  = lookupValid && !anyMatch;
    missPage = missReq ? lookupPage : '0;
    physAddr = hit ? {frameMem[selIdx], lookupOffset} : '0;
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, missReq, fault})); // R6
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> physAddr[OFFSET_W-1:0] == lookupOffset); // R2
  AST_MISS_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    missReq |-> (missPage == lookupPage) && (physAddr == '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !hit && !missReq && !fault && (physAddr == '0)); // R12
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> validVec == '0); // R5
  AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeEn |=> validVec[$past(writeIdx)] && (keyMem[$past(writeIdx)] == $past(fillPage))); // R4
  AST_NO_DUP_KEYS: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lookMatch)); // R10

endmodule

// File: rtl/xc_ctrl.sv
module xc_ctrl
  import xc_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flush,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillMatch,
  output strobe_t            strb,
  output logic [IDX_W-1:0]   writeIdx
);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] matchIdx;
  logic [IDX_W-1:0] emptyIdx;
  logic             hasMatch;
  logic             hasEmpty;

  always_comb begin
    matchIdx = '0;
    emptyIdx = '0;
    hasMatch = 1'b0;
    hasEmpty = 1'b0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (fillMatch[e]) begin
        matchIdx = IDX_W'(e);
        hasMatch = 1'b1;
      end
      if (!validVec[e]) begin
        emptyIdx = IDX_W'(e);
        hasEmpty = 1'b1;
      end
    end
  end

  always_comb begin
    strb.clearAll = flush;
    strb.writeEn  = fillValid && !flush;
    if (hasMatch)      writeIdx = matchIdx;
    else if (hasEmpty) writeIdx = emptyIdx;
    else               writeIdx = rrPtr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (strb.writeEn) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  AST_FILL_REUSES_KEY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeEn && (|fillMatch)) |-> fillMatch[writeIdx]); // R10
  AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (strb.writeEn && !(|fillMatch) && !(&validVec)) |-> !validVec[writeIdx]); // R8
  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> $stable(rrPtr)); // R11

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xc_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int PAGE_W   = 20,
  parameter int FRAME_W  = 17,
  parameter int OFFSET_W = 12,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PA_W    = FRAME_W + OFFSET_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lookupValid,
  input  logic [PAGE_W-1:0]   lookupPage,
  input  logic [OFFSET_W-1:0] lookupOffset,
  input  logic [1:0]          accessKind,
  input  logic                fillValid,
  input  logic [PAGE_W-1:0]   fillPage,
  input  logic [FRAME_W-1:0]  fillFrame,
  input  logic                fillPresent,
  input  logic                fillRead,
  input  logic                fillWrite,
  input  logic                fillExec,
  input  logic                flush,
  output logic [PA_W-1:0]     physAddr,
  output logic                hit,
  output logic                missReq,
  output logic [PAGE_W-1:0]   missPage,
  output logic                fault
);

  strobe_t            strb;
  logic [IDX_W-1:0]   writeIdx;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] fillMatch;
  perm_t              fillPerm;

  assign fillPerm = '{present: fillPresent, canRead: fillRead,
                      canWrite: fillWrite, canExec: fillExec};

  xc_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fillValid (fillValid),
    .flush     (flush),
    .validVec  (validVec),
    .fillMatch (fillMatch),
    .strb      (strb),
    .writeIdx  (writeIdx)
  );

  xc_array #(
    .ENTRIES  (ENTRIES),
    .PAGE_W   (PAGE_W),
    .FRAME_W  (FRAME_W),
    .OFFSET_W (OFFSET_W)
  ) u_array (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .writeIdx     (writeIdx),
    .fillPage     (fillPage),
    .fillFrame    (fillFrame),
    .fillPerm     (fillPerm),
    .lookupValid  (lookupValid),
    .lookupPage   (lookupPage),
    .lookupOffset (lookupOffset),
    .accessKind   (accessKind),
    .validVec     (validVec),
    .fillMatch    (fillMatch),
    .physAddr     (physAddr),
    .hit          (hit),
    .missReq      (missReq),
    .missPage     (missPage),
    .fault        (fault)
  );

endmodule

// File: tb/xlate_cache_bench.sv
`timescale 1ns/1ps
module xlate_cache_bench;

  localparam int N  = 4;
  localparam int PW = 8;
  localparam int FW = 6;
  localparam int OW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupValid = 1'b0;
  logic [PW-1:0] lookupPage = '0;
  logic [OW-1:0] lookupOffset = '0;
  logic [1:0]    accessKind = 2'b00;
  logic          fillValid = 1'b0;
  logic [PW-1:0] fillPage = '0;
  logic [FW-1:0] fillFrame = '0;
  logic          fillPresent = 1'b0;
  logic          fillRead = 1'b0;
  logic          fillWrite = 1'b0;
  logic          fillExec = 1'b0;
  logic          flush = 1'b0;
  logic [FW+OW-1:0] physAddr;
  logic          hit;
  logic          missReq;
  logic [PW-1:0] missPage;
  logic          fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xlate_cache #(.ENTRIES(N), .PAGE_W(PW), .FRAME_W(FW), .OFFSET_W(OW)) u_xlate_cache (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPage(lookupPage),
    .lookupOffset(lookupOffset), .accessKind(accessKind), .fillValid(fillValid),
    .fillPage(fillPage), .fillFrame(fillFrame), .fillPresent(fillPresent),
    .fillRead(fillRead), .fillWrite(fillWrite), .fillExec(fillExec), .flush(flush),
    .physAddr(physAddr), .hit(hit), .missReq(missReq), .missPage(missPage), .fault(fault)
  );

  task automatic look(input string req, input logic [PW-1:0] pg, input logic [OW-1:0] off,
                      input logic [1:0] kind, input logic eHit, input logic eFault,
                      input logic eMiss, input logic [FW-1:0] eFrame);
    logic [FW+OW-1:0] ePa;
    logic [PW-1:0]    ePg;
    @(negedge clk);
    lookupValid = 1'b1; lookupPage = pg; lookupOffset = off; accessKind = kind;
    #2;
    ePa = eHit ? {eFrame, off} : '0;
    ePg = eMiss ? pg : '0;
    checks++;
    if (hit !== eHit || fault !== eFault || missReq !== eMiss || physAddr !== ePa || missPage !== ePg) begin
      errors++;
      $display("FAIL %s page=%h kind=%0d: hit=%b fault=%b miss=%b pa=%h mp=%h, expected hit=%b fault=%b miss=%b pa=%h mp=%h",
               req, pg, kind, hit, fault, missReq, physAddr, missPage, eHit, eFault, eMiss, ePa, ePg);
    end
    lookupValid = 1'b0;
  endtask

  task automatic fill(input logic [PW-1:0] pg, input logic [FW-1:0] fr,
                      input logic p, input logic r, input logic w, input logic x,
                      input logic withFlush);
    @(negedge clk);
    fillValid = 1'b1; fillPage = pg; fillFrame = fr;
    fillPresent = p; fillRead = r; fillWrite = w; fillExec = x; flush = withFlush;
    @(negedge clk);
    fillValid = 1'b0; flush = 1'b0;
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic testReset();
    look("R1", 8'h11, 4'h0, 2'b00, 0, 0, 1, '0);
    look("R1", 8'h00, 4'h3, 2'b10, 0, 0, 1, '0);
    @(negedge clk);
    lookupValid = 1'b0; lookupPage = 8'h11; lookupOffset = 4'h5;
    #2;
    checks++;
    if (hit || missReq || fault || physAddr != '0 || missPage != '0) begin
      errors++;
      $display("FAIL R12 idle: hit=%b miss=%b fault=%b pa=%h mp=%h, expected all 0",
               hit, missReq, fault, physAddr, missPage);
    end
  endtask

  task automatic testBasic();
    fill(8'h10, 6'h21, 1, 1, 1, 1, 0);
    look("R4", 8'h10, 4'hA, 2'b00, 1, 0, 0, 6'h21);
    look("R2", 8'h10, 4'h3, 2'b01, 1, 0, 0, 6'h21);
    look("R3", 8'h55, 4'h7, 2'b00, 0, 0, 1, '0);
  endtask

  task automatic testPerms();
    fill(8'h30, 6'h05, 1, 1, 0, 0, 0);
    look("R6", 8'h30, 4'h1, 2'b00, 1, 0, 0, 6'h05);
    look("R6", 8'h30, 4'h1, 2'b01, 0, 1, 0, '0);
    look("R6", 8'h30, 4'h1, 2'b10, 0, 1, 0, '0);
    look("R6", 8'h30, 4'h1, 2'b11, 0, 1, 0, '0);
    fill(8'h31, 6'h06, 0, 1, 1, 1, 0);
    look("R7", 8'h31, 4'h2, 2'b00, 0, 1, 0, '0);
    look("R7", 8'h31, 4'h2, 2'b10, 0, 1, 0, '0);
    fill(8'h32, 6'h07, 1, 0, 1, 1, 0);
    look("R6", 8'h32, 4'hF, 2'b01, 1, 0, 0, 6'h07);
    look("R6", 8'h32, 4'hF, 2'b10, 1, 0, 0, 6'h07);
    look("R6", 8'h32, 4'hF, 2'b00, 0, 1, 0, '0);
  endtask

  // Four fills so far: pointer back at 0.
  task automatic testFlush();
    doFlush();
    look("R5", 8'h10, 4'h0, 2'b00, 0, 0, 1, '0);
    look("R5", 8'h32, 4'h0, 2'b01, 0, 0, 1, '0);
  endtask

  task automatic testReplace();
    fill(8'h41, 6'h01, 1, 1, 1, 1, 0);
    fill(8'h42, 6'h02, 1, 1, 1, 1, 0);
    fill(8'h43, 6'h03, 1, 1, 1, 1, 0);
    fill(8'h44, 6'h04, 1, 1, 1, 1, 0);
    fill(8'h45, 6'h05, 1, 1, 1, 1, 0); // slot 0
    fill(8'h46, 6'h06, 1, 1, 1, 1, 0); // slot 1
    look("R9", 8'h41, 4'h0, 2'b00, 0, 0, 1, '0);
    look("R9", 8'h42, 4'h0, 2'b00, 0, 0, 1, '0);
    look("R9", 8'h43, 4'h1, 2'b00, 1, 0, 0, 6'h03);
    look("R9", 8'h45, 4'h2, 2'b00, 1, 0, 0, 6'h05);
    look("R9", 8'h46, 4'h3, 2'b00, 1, 0, 0, 6'h06);
    fill(8'h43, 6'h3C, 1, 1, 1, 1, 0); // overwrite slot 2, pointer to 3
    look("R10", 8'h43, 4'h4, 2'b00, 1, 0, 0, 6'h3C);
    fill(8'h47, 6'h07, 1, 1, 1, 1, 0); // slot 3 replaces 0x44
    look("R10", 8'h44, 4'h0, 2'b00, 0, 0, 1, '0);
    look("R10", 8'h43, 4'h5, 2'b00, 1, 0, 0, 6'h3C);
    look("R9", 8'h47, 4'h6, 2'b00, 1, 0, 0, 6'h07);
  endtask

  task automatic testFlushWins();
    fill(8'h48, 6'h08, 1, 1, 1, 1, 1);
    look("R11", 8'h48, 4'h0, 2'b00, 0, 0, 1, '0);
    look("R11", 8'h47, 4'h0, 2'b00, 0, 0, 1, '0);
  endtask

  // Pointer is 0 here; one fill leaves it at 1, flush keeps it.
  task automatic testEmptyFirst();
    fill(8'h49, 6'h09, 1, 1, 1, 1, 0);
    doFlush();
    fill(8'h51, 6'h11, 1, 1, 1, 1, 0);
    fill(8'h52, 6'h12, 1, 1, 1, 1, 0);
    fill(8'h53, 6'h13, 1, 1, 1, 1, 0);
    fill(8'h54, 6'h14, 1, 1, 1, 1, 0);
    fill(8'h55, 6'h15, 1, 1, 1, 1, 0); // slot 1 holds 0x52
    look("R8", 8'h52, 4'h0, 2'b00, 0, 0, 1, '0);
    look("R8", 8'h51, 4'h8, 2'b00, 1, 0, 0, 6'h11);
    look("R8", 8'h53, 4'h9, 2'b00, 1, 0, 0, 6'h13);
    look("R8", 8'h55, 4'hB, 2'b10, 1, 0, 0, 6'h15);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testBasic();
    testPerms();
    testFlush();
    testReplace();
    testFlushWins();
    testEmptyFirst();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule